// File: doc/BRIEF.md
# Configurable Output Logic Macrocell

This block is one output cell of a programmable sum-of-products logic device. A row of product terms, made by an AND plane outside the block, arrives on `pt_sum`. The cell ORs the whole row into one sum. A D flip-flop samples that sum on every clock edge. A two-bit mode code then decides what reaches the pin: the sum taken straight through, or the stored bit, each in either polarity.

The pin is driven through an inverting driver that a dedicated product term, `pt_oe`, enables. When the driver is off, the cell drives nothing and the pin acts as an input. The cell also returns a literal pair, true and complement, to the AND plane. In the combinational modes this pair follows the pin level. In the registered modes it follows the inverted stored bit. A second product term, shared by all cells, clears the flip-flop.

The bidirectional pin is modelled as three separate signals: the driven value, the driver enable, and the level seen from outside.

Top module: `omc_macrocell`

## Requirements
- R1: `sum` is the OR of all NUM_TERMS bits of `pt_sum` (legal widths are 8, 10, 12, 14 and 16). Each bit position on its own sets the sum, and all bits at zero clear it.
- R2: With mode 2'b11 (bit 0 = S0, bit 1 = S1) and the driver enabled, `pin_out` equals `sum` in the same cycle.
- R3: With mode 2'b10 and the driver enabled, `pin_out` equals the inverse of `sum` in the same cycle.
- R4: The stored bit takes the value of `sum` on each rising clock edge. With mode 2'b01 and the driver enabled, `pin_out` shows the stored bit.
- R5: With mode 2'b00 and the driver enabled, `pin_out` shows the inverse of the stored bit.
- R6: When `pt_clr` is high at a rising edge, the stored bit becomes 0 in every mode, whatever the value of `sum`.
- R7: When `rst_n` is low at a rising edge, the stored bit becomes 0.
- R8: `pin_oe` follows `pt_oe`. When `pt_oe` is 0, `pin_out` is 0 and the cell does not drive the pin.
- R9: When mode bit 1 is 1, `fb_true` equals the pin level. The pin level is `pin_out` while the driver is on, and `pin_in` while it is off.
- R10: When mode bit 1 is 0, `fb_true` equals the inverse of the stored bit, and `pin_in` has no effect on it.
- R11: `fb_comp` is always the inverse of `fb_true`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pt_sum | input | NUM_TERMS | Product terms that feed the OR |
| pt_oe | input | 1 | Product term that enables the driver |
| pt_clr | input | 1 | Shared product term that clears the flip-flop |
| mode | input | 2 | Mode code, bit 0 = S0, bit 1 = S1 |
| pin_in | input | 1 | Level applied to the pin from outside |
| pin_out | output | 1 | Value the driver puts on the pin |
| pin_oe | output | 1 | Driver enable |
| fb_true | output | 1 | True feedback literal to the AND plane |
| fb_comp | output | 1 | Complement feedback literal |

## Verification
The OR is tried in two ways: with each product-term bit set on its own, and with all bits clear. These cases show that every term position reaches the sum and that no position is wired to a constant. Random words then run through all four mode codes with the driver both on and off. Comparing the same `sum` in opposite polarities shows whether the path is combinational or delayed by one cycle, and whether the polarity is correct. Directed sequences hold `pt_clr` high while `sum` is 1, and toggle `pin_in` in registered mode, to show that clearing takes priority over capture and that the feedback source changes with mode bit 1.

// File: rtl/omc_pkg.sv
// Shared types for the output macrocell.
// Assumes a 2-bit mode code laid out as {S1, S0}.
package omc_pkg;

    // Mode codes. S1 = 1 selects the combinational path, S0 = 1 selects
    // the active-high polarity at the pin.
    typedef enum logic [1:0] {
        OMC_REG_LOW   = 2'b00,
        OMC_REG_HIGH  = 2'b01,
        OMC_COMB_LOW  = 2'b10,
        OMC_COMB_HIGH = 2'b11
    } omc_mode_e;

    localparam int OMC_MIN_TERMS = 8;
    localparam int OMC_MAX_TERMS = 16;

endpackage

// File: rtl/omc_or_plane.sv
// OR of one row of product terms.
// Assumes NUM_TERMS is even and lies between 8 and 16.
// The OR is built as a chain of partial ORs.
module omc_or_plane #(
    parameter int NUM_TERMS = 8
) (
    input  logic [NUM_TERMS-1:0] terms,
    output logic                 sum
);
    import omc_pkg::*;

    logic [NUM_TERMS:0] partial;

    generate
        if (NUM_TERMS < OMC_MIN_TERMS || NUM_TERMS > OMC_MAX_TERMS
            || (NUM_TERMS % 2) != 0) begin : g_bad_width
            $error("omc_or_plane: NUM_TERMS must be 8, 10, 12, 14 or 16");
        end
    endgenerate

    assign partial[0] = 1'b0;

    // Partial OR chain: stage i adds term i to the running OR
    generate
        for (genvar i = 0; i < NUM_TERMS; i++) begin : g_chain
            assign partial[i+1] = partial[i] | terms[i];
        end
    endgenerate

    assign sum = partial[NUM_TERMS];

endmodule

// File: rtl/omc_store.sv
// D flip-flop that samples the OR sum.
// Assumes rst_n and clr are synchronous, and that both clear the bit to 0.
module omc_store (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic d,
    output logic q
);

    // Capture the sum each edge. Reset and the shared clear take priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (clr) begin
            q <= 1'b0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/omc_pin_drive.sv
// Four-way mode selector and inverting pin driver.
// When disabled, the driver model outputs 0 and drops its enable.
module omc_pin_drive (
    input  logic [1:0] mode,
    input  logic       sum,
    input  logic       q,
    input  logic       oe,
    output logic       pin_out,
    output logic       pin_oe
);
    import omc_pkg::*;

    logic sel;

    // Choose the source before the inverting driver
    always_comb begin
        unique case (omc_mode_e'(mode))
            OMC_REG_LOW:   sel = q;
            OMC_REG_HIGH:  sel = ~q;
            OMC_COMB_LOW:  sel = sum;
            OMC_COMB_HIGH: sel = ~sum;
            default:       sel = sum;
        endcase
    end

    // Inverting driver with enable
    always_comb begin
        pin_oe  = oe;
        pin_out = oe ? ~sel : 1'b0;
    end

endmodule

// File: rtl/omc_feedback.sv
// Feedback selector to the AND plane.
// S1 = 1 takes the pin level, S1 = 0 takes the inverted stored bit.
// Assumes the pin level is resolved from the driver state.
module omc_feedback (
    input  logic s1,
    input  logic q,
    input  logic pin_out,
    input  logic pin_oe,
    input  logic pin_in,
    output logic fb_true,
    output logic fb_comp
);

    logic pin_level;

    // Resolve the pin: the own driver wins when enabled
    always_comb begin
        pin_level = pin_oe ? pin_out : pin_in;
    end

    // Choose the source and form the literal pair
    always_comb begin
        fb_true = s1 ? pin_level : ~q;
        fb_comp = ~fb_true;
    end

endmodule

// File: rtl/omc_macrocell.sv
// Top of one configurable output macrocell.
// Wires the OR, the flip-flop, the pin driver and the feedback selector.
// Assumes mode is a static configuration, though changing it between
// cycles is legal.
module omc_macrocell #(
    parameter int NUM_TERMS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_TERMS-1:0] pt_sum,
    input  logic                 pt_oe,
    input  logic                 pt_clr,
    input  logic [1:0]           mode,
    input  logic                 pin_in,
    output logic                 pin_out,
    output logic                 pin_oe,
    output logic                 fb_true,
    output logic                 fb_comp
);

    logic sum;
    logic q;

    omc_or_plane #(.NUM_TERMS(NUM_TERMS)) u_or (
        .terms (pt_sum),
        .sum   (sum)
    );

    omc_store u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pt_clr),
        .d     (sum),
        .q     (q)
    );

    omc_pin_drive u_drive (
        .mode    (mode),
        .sum     (sum),
        .q       (q),
        .oe      (pt_oe),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    omc_feedback u_fb (
        .s1      (mode[1]),
        .q       (q),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .pin_in  (pin_in),
        .fb_true (fb_true),
        .fb_comp (fb_comp)
    );

endmodule

// File: rtl/omc_macrocell_sva.sv
// Assertion checker for omc_macrocell, attached through a bind statement.
// It sees only the ports of the cell.
module omc_macrocell_sva #(
    parameter int NUM_TERMS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_TERMS-1:0] pt_sum,
    input logic                 pt_oe,
    input logic                 pt_clr,
    input logic [1:0]           mode,
    input logic                 pin_in,
    input logic                 pin_out,
    input logic                 pin_oe,
    input logic                 fb_true,
    input logic                 fb_comp
);

    AST_COMB_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_oe && mode == 2'b11) |-> (pin_out == (|pt_sum))); // R2
    AST_COMB_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_oe && mode == 2'b10) |-> (pin_out == !(|pt_sum))); // R3
    AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pt_clr && !mode[1]) |=> (mode[1] || fb_comp == $past(|pt_sum))); // R4
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        pt_clr |=> (mode[1] || fb_true)); // R6
    AST_DRIVER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !pt_oe |-> (!pin_oe && !pin_out)); // R8
    AST_FB_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && !pt_oe) |-> (fb_true == pin_in)); // R9
    AST_FB_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        fb_true != fb_comp); // R11

endmodule

bind omc_macrocell omc_macrocell_sva #(.NUM_TERMS(NUM_TERMS)) u_sva (
    .clk     (clk),
    .rst_n   (rst_n),
    .pt_sum  (pt_sum),
    .pt_oe   (pt_oe),
    .pt_clr  (pt_clr),
    .mode    (mode),
    .pin_in  (pin_in),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .fb_true (fb_true),
    .fb_comp (fb_comp)
);

// File: tb/omc_macrocell_tb.sv
// Self-checking bench for omc_macrocell.
// Uses directed corner cases plus fixed-seed random stimulus.
module omc_macrocell_tb;

    localparam int NT = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NT-1:0] pt_sum = '0;
    logic          pt_oe = 1'b0;
    logic          pt_clr = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic          pin_in = 1'b0;
    logic          pin_out, pin_oe, fb_true, fb_comp;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    logic q_m = 1'b0;

    omc_macrocell #(.NUM_TERMS(NT)) u_dut (
        .clk(clk), .rst_n(rst_n), .pt_sum(pt_sum), .pt_oe(pt_oe),
        .pt_clr(pt_clr), .mode(mode), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .fb_true(fb_true), .fb_comp(fb_comp)
    );

    always #10 clk = ~clk;

    // Reference flip-flop model (R4, R6, R7)
    always @(posedge clk) q_m <= (!rst_n || pt_clr) ? 1'b0 : (|pt_sum);

    function automatic logic exp_pin(logic [1:0] m, logic s, logic q, logic oe);
        logic src;
        case (m)
            2'b00: src = ~q;
            2'b01: src = q;
            2'b10: src = ~s;
            default: src = s;
        endcase
        return oe ? src : 1'b0;
    endfunction

    function automatic logic exp_fb(logic [1:0] m, logic s, logic q, logic oe, logic pi);
        if (m[1]) return oe ? exp_pin(m, s, q, oe) : pi;
        return ~q;
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Compare every output against the model at the current inputs
    task automatic check_all(string pin_tag);
        logic s;
        logic ep;
        logic ef;
        s  = |pt_sum;
        ep = exp_pin(mode, s, q_m, pt_oe);
        ef = exp_fb(mode, s, q_m, pt_oe, pin_in);
        chk("R8 pin_oe", pin_oe, pt_oe);
        chk(pin_tag, pin_out, ep);
        chk(mode[1] ? "R9 fb_true" : "R10 fb_true", fb_true, ef);
        chk("R11 fb_comp", fb_comp, ~ef);
    endtask

    function automatic string tag_for_mode(logic [1:0] m, logic oe);
        if (!oe) return "R8 pin_out";
        case (m)
            2'b00: return "R5 pin_out";
            2'b01: return "R4 pin_out";
            2'b10: return "R3 pin_out";
            default: return "R2 pin_out";
        endcase
    endfunction

    // Apply inputs at the falling edge and check after they settle
    task automatic apply(logic [NT-1:0] t, logic oe, logic cl, logic [1:0] m,
                         logic pi, string tag);
        @(negedge clk);
        pt_sum = t; pt_oe = oe; pt_clr = cl; mode = m; pin_in = pi;
        #2;
        check_all(tag);
    endtask

    initial begin
        int unsigned seed;
        // Reset state (R7): the stored bit is 0, so mode 00 drives 1
        rst_n = 1'b0;
        pt_sum = '1;
        pt_oe = 1'b1;
        mode = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #2;
        chk("R7 reset pin_out", pin_out, 1'b1);
        chk("R7 reset fb_true", fb_true, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: each term alone, then all clear, with the combinational high mode
        for (int i = 0; i < NT; i++) begin
            apply(NT'(1) << i, 1'b1, 1'b0, 2'b11, 1'b0, "R1 single term");
        end
        apply('0, 1'b1, 1'b0, 2'b11, 1'b0, "R1 all clear");

        // R4: capture 1, then observe it one cycle later in mode 01
        apply('1, 1'b1, 1'b0, 2'b01, 1'b0, "R4 pin_out");
        apply('0, 1'b1, 1'b0, 2'b01, 1'b0, "R4 captured one");
        chk("R4 held one", pin_out, 1'b1);

        // R6: clear wins over a set sum, in a combinational mode
        apply('1, 1'b1, 1'b0, 2'b11, 1'b0, "R2 pin_out");
        apply('1, 1'b1, 1'b1, 2'b11, 1'b0, "R2 pin_out");
        apply('1, 1'b1, 1'b0, 2'b01, 1'b0, "R6 cleared");
        chk("R6 cleared bit", pin_out, 1'b0);

        // R10: in registered mode pin_in is ignored by the feedback
        apply('0, 1'b0, 1'b0, 2'b00, 1'b0, "R8 pin_out");
        apply('0, 1'b0, 1'b0, 2'b00, 1'b1, "R10 pin_in ignored");
        apply('0, 1'b0, 1'b0, 2'b10, 1'b1, "R9 pin_in used");
        chk("R9 pin level", fb_true, 1'b1);

        // Random mixture of all modes, driver states and clears
        seed = 32'h5eed_0c1;
        void'($urandom(seed));
        for (int n = 0; n < 600; n++) begin
            logic [31:0] r;
            logic [1:0]  m;
            logic        oe;
            r  = $urandom();
            m  = r[1:0];
            oe = r[2] | r[3];
            apply(r[8 +: NT] & (r[4] ? '1 : NT'(r[20 +: NT])), oe,
                  (r[5:4] == 2'b11), m, r[6], tag_for_mode(m, oe));
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(200000 * 20);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule